// File: doc/BRIEF.md
# Serial-Bus EEPROM Slave (1 Kbit, word or byte organised)

This block models a 1 Kbit electrically erasable memory reached over a four-wire serial bus. The wires are a select, a serial clock, a data input and a data output with its enable. A fast system clock oversamples all three bus inputs. Every transaction opens when the select rises while the serial clock is low. A start bit follows, then a two-bit opcode, then an address. Write-type commands also carry data. The array holds 64 words of 16 bits. The same storage can be addressed as 128 bytes when the organisation input is low.

Reads stream out most significant bit first, and the address advances after each unit. Programming commands update the array and then start a self-timed busy period of `PROG_CYCLES` system clocks. During that period the data output shows busy (low) whenever the select is high, and it turns high once the period ends. An enable latch, cleared at reset, guards every command that modifies the array.

The controller is one state machine:
- `ST_IDLE`: the select is low.
- `ST_HUNT`: waiting for the start bit.
- `ST_OPC`: receiving the opcode.
- `ST_ADR`: receiving the address.
- `ST_DAT`: receiving write data.
- `ST_RD`: streaming read data.
- `ST_DONE`: the frame is finished or rejected, and the block waits for the select to drop.

Transitions:
- A low select forces `ST_IDLE` from any state.
- Select high leaves `ST_IDLE`. It goes to `ST_HUNT` if the clock was low and no cycle is running; otherwise it goes to `ST_DONE`.
- A sampled 1 moves `ST_HUNT` to `ST_OPC`.
- The second opcode bit moves `ST_OPC` to `ST_ADR`.
- The last address bit leaves `ST_ADR`. A READ goes to `ST_RD`; a WRITE or write-all goes to `ST_DAT`; every other command goes to `ST_DONE`.
- The last data bit moves `ST_DAT` to `ST_DONE`.

Top module: `uw_eeprom`

## Requirements
- R1: During and after reset `bus_dout_en` is 0. It is 1 while `bus_sel` is high and 0 while `bus_sel` is low. With no cycle running and no read in progress, `bus_dout` is 1 while selected.
- R2: A frame opens only when `bus_sel` rises while `bus_clk` is low. Zeros sampled before the first 1 are skipped. If `bus_sel` rises while `bus_clk` is high, the whole selection is ignored.
- R3: The opcode bits are decoded as 10 = READ, 01 = WRITE, 11 = ERASE one location, and 00 = special. For a special, the two top address bits select the command: 11 = enable, 00 = disable, 10 = erase all, 01 = write all. The remaining address bits are ignored.
- R4: `word_mode` = 1 selects 16-bit units with a 6-bit address. `word_mode` = 0 selects bytes with a 7-bit address. Byte address a maps to bits [15:8] of word a>>1 when a[0] = 1, and to bits [7:0] otherwise. READ/WRITE frames are 25 clocks (word) or 18 clocks (byte). The other non-data frames are 9 or 10 clocks.
- R5: A READ outputs one 0 on the rising clock edge of the last address bit. On each following rising edge it outputs the next data bit, MSB first.
- R6: While the select stays high, a READ continues with the next unit after each unit. The address wraps from 63 (word) or 127 (byte) to 0.
- R7: WRITE, ERASE, erase all and write all have no effect unless an enable has been received after reset and after the most recent disable.
- R8: WRITE overwrites a unit with no prior erase. ERASE sets a unit to all ones. Erase all sets every bit to 1. Write all copies the data into every unit.
- R9: Each accepted programming command starts a busy period of exactly `PROG_CYCLES` system clocks. During it, `bus_dout` is 0 while selected. Afterwards it returns to 1.
- R10: Frames received while busy are ignored, and that includes enable and disable.
- R11: Dropping `bus_sel` in the middle of a frame discards the frame. Nothing is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset (stands in for power-on) |
| bus_sel | input | 1 | Bus select, active high |
| bus_clk | input | 1 | Serial clock from the bus master |
| bus_din | input | 1 | Serial data into the block |
| word_mode | input | 1 | 1 = 16-bit organisation, 0 = 8-bit organisation |
| bus_dout | output | 1 | Serial read data or busy/ready status |
| bus_dout_en | output | 1 | Output enable for `bus_dout` |

## Verification
The bench builds the block with `PROG_CYCLES` = 600 and the default 64 x 16 array. At a bus half-period of 6 system clocks, a whole 25-clock WRITE frame fits inside one busy period. This makes it possible to issue an enable-disable frame and a second WRITE while programming runs, and then show that both were dropped. The short array lets a single stream cover every word plus the wrap back to address 0. Byte-organised writes are read back as words, which checks the lane mapping.

// File: rtl/uw_pkg.sv
`timescale 1ns/1ps
package uw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_RD,
        ST_DONE
    } uw_state_t;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SP_DISABLE = 2'b00;
    localparam logic [1:0] SP_WRALL   = 2'b01;
    localparam logic [1:0] SP_ERALL   = 2'b10;
    localparam logic [1:0] SP_ENABLE  = 2'b11;
endpackage

// File: rtl/uw_sync.sv
`timescale 1ns/1ps
module uw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sck_i,
    input  logic din_i,
    output logic sel_o,
    output logic sck_o,
    output logic din_o,
    output logic sck_rise_o
);
    logic [1:0] sel_q, sck_q, din_q;
    logic       sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            sck_q <= '0;
            din_q <= '0;
            sck_d <= 1'b0;
        end else begin
            sel_q <= {sel_q[0], sel_i};
            sck_q <= {sck_q[0], sck_i};
            din_q <= {din_q[0], din_i};
            sck_d <= sck_q[1];
        end
    end

    assign sel_o      = sel_q[1];
    assign sck_o      = sck_q[1];
    assign din_o      = din_q[1];
    assign sck_rise_o = sck_q[1] & ~sck_d;
endmodule

// File: rtl/uw_prog_timer.sv
`timescale 1ns/1ps
module uw_prog_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (start && remain == '0)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - CW'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/uw_array.sv
`timescale 1ns/1ps
module uw_array #(
    parameter int WORDS = 64,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic                     we_all,
    input  logic                     byte_mode,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic                     hi_lane,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    localparam int AW = $clog2(WORDS);
    localparam int HW = DW / 2;

    logic [WORDS-1:0][DW-1:0] flat;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (we && (we_all || waddr == AW'(i))) begin
                if (we_all || !byte_mode)
                    word_q <= wdata;
                else if (hi_lane)
                    word_q[DW-1:HW] <= wdata[HW-1:0];
                else
                    word_q[HW-1:0] <= wdata[HW-1:0];
            end
        end
        assign flat[i] = word_q;
    end

    assign rdata = flat[raddr];
endmodule

// File: rtl/uw_eeprom.sv
`timescale 1ns/1ps
module uw_eeprom #(
    parameter int WORDS       = 64,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_sel,
    input  logic bus_clk,
    input  logic bus_din,
    input  logic word_mode,
    output logic bus_dout,
    output logic bus_dout_en
);
    import uw_pkg::*;

    localparam int WAW  = $clog2(WORDS);
    localparam int BAW  = WAW + 1;
    localparam int BW   = DW / 2;
    localparam int CNTW = $clog2(DW + 1);

    logic            cs_s, sck_s, din_s, sck_rise;
    logic            busy, prog_start, prog_all, prog_erase;
    uw_state_t       state, state_n;
    logic [CNTW-1:0] cnt, adr_last, dat_last;
    logic [1:0]      opc, top2;
    logic [BAW-1:0]  ash, addr_full, wa_src, rd_addr, rd_next;
    logic [DW-1:0]   dsh, data_full, wdata, arr_wdata, rdata, rword, osh;
    logic [WAW-1:0]  waddr, raddr;
    logic            ewen, obit;

    uw_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .sck_i(bus_clk), .din_i(bus_din),
        .sel_o(cs_s), .sck_o(sck_s), .din_o(din_s), .sck_rise_o(sck_rise)
    );

    uw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    // field decode
    assign adr_last  = word_mode ? CNTW'(WAW - 1) : CNTW'(BAW - 1);
    assign dat_last  = word_mode ? CNTW'(DW - 1)  : CNTW'(BW - 1);
    assign addr_full = {ash[BAW-2:0], din_s};
    assign top2      = word_mode ? addr_full[WAW-1:WAW-2] : addr_full[BAW-1:BAW-2];
    assign data_full = {dsh[DW-2:0], din_s};
    assign wdata     = word_mode ? data_full : {data_full[BW-1:0], data_full[BW-1:0]};
    assign arr_wdata = prog_erase ? '1 : wdata;
    assign wa_src    = (state == ST_ADR) ? addr_full : ash;
    assign waddr     = word_mode ? wa_src[WAW-1:0] : wa_src[BAW-1:1];
    assign raddr     = word_mode ? rd_addr[WAW-1:0] : rd_addr[BAW-1:1];
    assign rword     = word_mode ? rdata
                     : {(rd_addr[0] ? rdata[DW-1:BW] : rdata[BW-1:0]), {BW{1'b0}}};
    assign rd_next   = word_mode ? {1'b0, rd_addr[WAW-1:0] + WAW'(1)} : rd_addr + BAW'(1);

    uw_array #(.WORDS(WORDS), .DW(DW)) u_array (
        .clk(clk), .we(prog_start), .we_all(prog_all), .byte_mode(~word_mode),
        .waddr(waddr), .hi_lane(wa_src[0]), .wdata(arr_wdata),
        .raddr(raddr), .rdata(rdata)
    );

    // programming launch
    always_comb begin
        prog_start = 1'b0;
        prog_all   = 1'b0;
        prog_erase = 1'b0;
        if (cs_s && sck_rise && ewen) begin
            if (state == ST_ADR && cnt == adr_last) begin
                if (opc == OP_ERASE) begin
                    prog_start = 1'b1;
                    prog_erase = 1'b1;
                end else if (opc == OP_SPECIAL && top2 == SP_ERALL) begin
                    prog_start = 1'b1;
                    prog_erase = 1'b1;
                    prog_all   = 1'b1;
                end
            end else if (state == ST_DAT && cnt == dat_last) begin
                if (opc == OP_WRITE) begin
                    prog_start = 1'b1;
                end else if (opc == OP_SPECIAL) begin
                    prog_start = 1'b1;
                    prog_all   = 1'b1;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        if (!cs_s) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_n = (busy || sck_s) ? ST_DONE : ST_HUNT;
                ST_HUNT: if (sck_rise && din_s) state_n = ST_OPC;
                ST_OPC:  if (sck_rise && cnt == CNTW'(1)) state_n = ST_ADR;
                ST_ADR: begin
                    if (sck_rise && cnt == adr_last) begin
                        if (opc == OP_READ)
                            state_n = ST_RD;
                        else if (opc == OP_WRITE || (opc == OP_SPECIAL && top2 == SP_WRALL))
                            state_n = ST_DAT;
                        else
                            state_n = ST_DONE;
                    end
                end
                ST_DAT:  if (sck_rise && cnt == dat_last) state_n = ST_DONE;
                ST_RD:   state_n = ST_RD;
                ST_DONE: state_n = ST_DONE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            opc     <= '0;
            ash     <= '0;
            dsh     <= '0;
            ewen    <= 1'b0;
            rd_addr <= '0;
            osh     <= '0;
            obit    <= 1'b0;
        end else begin
            if (state_n != state)
                cnt <= '0;
            else if (sck_rise && state != ST_RD)
                cnt <= cnt + CNTW'(1);
            case (state)
                ST_IDLE: begin
                    opc <= '0;
                    ash <= '0;
                    dsh <= '0;
                end
                ST_OPC: if (sck_rise) opc <= {opc[0], din_s};
                ST_ADR: begin
                    if (sck_rise) begin
                        ash <= addr_full;
                        if (cnt == adr_last) begin
                            rd_addr <= word_mode ? {1'b0, addr_full[WAW-1:0]} : addr_full;
                            obit    <= 1'b0;
                            if (opc == OP_SPECIAL && top2 == SP_ENABLE)  ewen <= 1'b1;
                            if (opc == OP_SPECIAL && top2 == SP_DISABLE) ewen <= 1'b0;
                        end
                    end
                end
                ST_DAT: if (sck_rise) dsh <= data_full;
                ST_RD: begin
                    if (sck_rise) begin
                        if (cnt == '0) begin
                            obit    <= rword[DW-1];
                            osh     <= {rword[DW-2:0], 1'b0};
                            cnt     <= dat_last;
                            rd_addr <= rd_next;
                        end else begin
                            obit <= osh[DW-1];
                            osh  <= {osh[DW-2:0], 1'b0};
                            cnt  <= cnt - CNTW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_dout_en = cs_s;
        bus_dout    = (state == ST_RD) ? obit : ~busy;
    end
endmodule

// File: rtl/uw_eeprom_chk.sv
`timescale 1ns/1ps
module uw_eeprom_chk #(
    parameter int PROG_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input uw_pkg::uw_state_t state,
    input logic              busy,
    input logic              ewen,
    input logic              bus_dout
);
    import uw_pkg::*;

    int run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_discard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> state == ST_IDLE);

    assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == PROG_CYCLES);

    assert_prog_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ewen));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state == ST_IDLE || state == ST_DONE));

    assert_dummy_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD && $past(state) != ST_RD) |-> !bus_dout);

    assert_enable_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ewen) |-> $past(state) == ST_ADR);
endmodule

bind uw_eeprom uw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .state(state),
    .busy(busy), .ewen(ewen), .bus_dout(bus_dout)
);

// File: tb/sim_uw_eeprom.sv
`timescale 1ns/1ps
module sim_uw_eeprom;
    localparam int PROG = 600;
    localparam int HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_clk = 1'b0, bus_din = 1'b0, word_mode = 1'b1;
    logic bus_dout, bus_dout_en;
    int vectors = 0, miscompares = 0;
    logic [15:0] mw [64];
    bit wen_m = 1'b0;

    always #2 clk = ~clk;

    uw_eeprom #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_clk(bus_clk),
        .bus_din(bus_din), .word_mode(word_mode),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic q);
        bus_din = b;
        wait_clk(HALF);
        bus_clk = 1'b1;
        wait_clk(HALF);
        q = bus_dout;
        bus_clk = 1'b0;
    endtask

    task automatic sel();
        bus_clk = 1'b0;
        bus_sel = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic desel();
        bus_sel = 1'b0;
        bus_clk = 1'b0;
        bus_din = 1'b0;
        wait_clk(HALF);
    endtask

    function automatic int aw();
        return word_mode ? 6 : 7;
    endfunction

    function automatic int dw();
        return word_mode ? 16 : 8;
    endfunction

    function automatic int sp_addr(input logic [1:0] t2);
        return word_mode ? int'(t2) << 4 : int'(t2) << 5;
    endfunction

    function automatic logic [15:0] model_rd(input int a);
        int b;
        if (word_mode) return mw[a % 64];
        b = a % 128;
        return b[0] ? {8'h00, mw[b >> 1][15:8]} : {8'h00, mw[b >> 1][7:0]};
    endfunction

    function automatic void model_wr(input int a, input logic [15:0] d);
        if (!wen_m) return;
        if (word_mode) mw[a] = d;
        else if (a[0]) mw[a >> 1][15:8] = d[7:0];
        else mw[a >> 1][7:0] = d[7:0];
    endfunction

    function automatic void model_all(input logic [15:0] d);
        if (!wen_m) return;
        for (int i = 0; i < 64; i++) mw[i] = word_mode ? d : {d[7:0], d[7:0]};
    endfunction

    task automatic hdr(input logic [1:0] op, input int addr, input int lz, output logic q);
        sel();
        for (int i = 0; i < lz; i++) bit_x(1'b0, q);
        bit_x(1'b1, q);
        bit_x(op[1], q);
        bit_x(op[0], q);
        for (int i = aw() - 1; i >= 0; i--) bit_x(addr[i], q);
    endtask

    task automatic rd(input int addr, input int n, input int lz, input string req);
        logic q;
        logic [15:0] got;
        hdr(2'b10, addr, lz, q);
        chk("R5 dummy bit", {15'b0, q}, 16'h0000);
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int b = 0; b < dw(); b++) begin
                bit_x(1'b0, q);
                got = {got[14:0], q};
            end
            chk(req, got, model_rd(addr + k));
        end
        desel();
    endtask

    task automatic cmd(input logic [1:0] op, input int addr, input logic [15:0] data, input bit has_data);
        logic q;
        hdr(op, addr, 0, q);
        if (has_data)
            for (int b = dw() - 1; b >= 0; b--) bit_x(data[b], q);
        desel();
    endtask

    task automatic wait_ready(input string req, input bit expect_busy);
        int n;
        n = 0;
        sel();
        chk(req, {15'b0, bus_dout}, expect_busy ? 16'h0000 : 16'h0001);
        while (bus_dout !== 1'b1 && n < 4 * PROG) begin
            wait_clk(1);
            n++;
        end
        chk("R9 ready after cycle", {15'b0, bus_dout}, 16'h0001);
        desel();
    endtask

    task automatic wr(input int addr, input logic [15:0] d, input string req);
        cmd(2'b01, addr, d, 1'b1);
        model_wr(addr, d);
        wait_ready(req, wen_m);
    endtask

    task automatic special(input logic [1:0] t2, input logic [15:0] d);
        cmd(2'b00, sp_addr(t2), d, t2 == 2'b01);
        if (t2 == 2'b11) wen_m = 1'b1;
        if (t2 == 2'b00) wen_m = 1'b0;
        if (t2 == 2'b10) model_all(16'hFFFF);
        if (t2 == 2'b01) model_all(d);
        if (t2 == 2'b10 || t2 == 2'b01) wait_ready("R9 busy after bulk", wen_m);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R9: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int a, seed;
        logic q;
        logic [15:0] d;
        seed = $urandom(32'h5EED);
        wait_clk(5);
        chk("R1 reset output enable", {15'b0, bus_dout_en}, 16'h0000);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 released when deselected", {15'b0, bus_dout_en}, 16'h0000);
        sel();
        chk("R1 enabled when selected", {15'b0, bus_dout_en}, 16'h0001);
        chk("R1 ready after reset", {15'b0, bus_dout}, 16'h0001);
        desel();

        // R7: write before enable launches nothing
        wr(5, 16'h1234, "R7 no cycle while protected");

        // R3 enable, R8 erase all, R6 full stream with wrap
        special(2'b11, 16'h0);
        special(2'b10, 16'h0);
        rd(0, 66, 0, "R6 R8 erase-all stream");

        // R8 random word writes, R2 leading zeros
        for (int i = 0; i < 16; i++) begin
            a = $urandom % 64;
            d = 16'($urandom);
            wr(a, d, "R9 busy after write");
            rd(a, 1, i % 3, "R8 R2 word readback");
        end
        wr(62, 16'hBEEF, "R9 busy after write");
        wr(63, 16'hCAFE, "R9 busy after write");
        wr(0, 16'h0F0F, "R9 busy after write");
        rd(62, 4, 0, "R6 word wrap");

        // R8 single erase
        cmd(2'b11, 62, 16'h0, 1'b0);
        model_wr(62, 16'hFFFF);
        wait_ready("R9 busy after erase", 1'b1);
        rd(62, 1, 0, "R8 erase one");

        // R4 byte organisation
        word_mode = 1'b0;
        wr(10, 16'h003C, "R9 busy after byte write");
        wr(11, 16'h00A7, "R9 busy after byte write");
        for (int i = 0; i < 8; i++) begin
            a = $urandom % 128;
            wr(a, 16'($urandom % 256), "R9 busy after byte write");
            rd(a, 1, 0, "R4 byte readback");
        end
        rd(125, 5, 0, "R6 byte wrap");
        word_mode = 1'b1;
        rd(5, 1, 0, "R4 byte lane mapping");

        // R8 write all
        special(2'b01, 16'hA5C3);
        rd(20, 3, 0, "R8 write-all");
        word_mode = 1'b0;
        special(2'b01, 16'h005A);
        rd(40, 2, 0, "R8 byte write-all");
        word_mode = 1'b1;

        // R10: frames during busy are ignored
        cmd(2'b01, 7, 16'h7777, 1'b1);
        model_wr(7, 16'h7777);
        cmd(2'b00, sp_addr(2'b00), 16'h0, 1'b0);
        cmd(2'b01, 8, 16'h8888, 1'b1);
        wait_ready("R10 still busy", 1'b1);
        rd(7, 2, 0, "R10 second write dropped");
        wr(9, 16'h9999, "R10 disable while busy dropped");
        rd(9, 1, 0, "R10 enable kept");

        // R11: partial frame discarded
        sel();
        bit_x(1'b1, q); bit_x(1'b0, q); bit_x(1'b1, q);
        bit_x(1'b0, q); bit_x(1'b1, q); bit_x(1'b1, q);
        desel();
        sel();
        chk("R11 no cycle after abort", {15'b0, bus_dout}, 16'h0001);
        desel();
        rd(11, 1, 0, "R11 location untouched");

        // R2: select rising with clock high ignores the frame
        bus_clk = 1'b1;
        wait_clk(HALF);
        bus_sel = 1'b1;
        wait_clk(HALF);
        bus_clk = 1'b0;
        bit_x(1'b1, q); bit_x(1'b1, q); bit_x(1'b0, q);
        for (int i = 0; i < 6; i++) bit_x(1'b0, q);
        chk("R2 no read when clock high at select", {15'b0, q}, 16'h0001);
        desel();

        // R7: disable then write is refused
        special(2'b00, 16'h0);
        wr(3, 16'h3333, "R7 no cycle after disable");
        rd(3, 1, 0, "R7 content kept");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule